// File: doc/BRIEF.md
# ISA Bus Cycle Timing Generator

This block is a bus master that runs one 8-bit or 16-bit memory or I/O read or write cycle at a time on an ISA-style expansion bus. It is clocked at 100 MHz, so one clock is 10 ns. A host presents a 32-bit address, write data and a direction. The top address byte selects the cycle kind. The block then drives a setup phase, a strobe phase and a fixed hold phase. When the hold phase ends it returns read data and a one-cycle done pulse.

A configuration word sets the phase lengths. The setup and strobe lengths each take a count of extra clocks added to a two-clock floor. When enabled, an active-low early-end input from the target cuts the strobe short; that input passes through a two-flop synchroniser first. Two further configuration bits are brought out as plain outputs for the surrounding pin multiplexing and clock selection.

Top module: `isa_cycle_gen`

## Requirements
- R1: After reset the strobe-extra field is 40 and the setup-extra field is 14 (cfg_rdata = 0x3A8). All four strobes are high, bus_active and done are low, and req_ready is high.
- R2: A configuration write stores bits 5:0 (strobe extra), 9:6 (setup extra), 10 (early-end enable), 11 and 12. All bits above 12 read back as zero.
- R3: Address bits 31:24 pick the cycle: 0xEC is 8-bit memory, 0xED is 16-bit memory, 0xEE is 8-bit I/O, 0xEF is 16-bit I/O. A request with any other top byte is ignored: no bus activity and no done.
- R4: The setup phase lasts setup-extra + 2 clocks with no strobe low. bus_addr (request bits 23:0) and bus_dout stay stable from the start of setup to the end of hold.
- R5: The strobe phase lasts strobe-extra + 2 clocks. Exactly one strobe is low: ior_n for an I/O read, iow_n for an I/O write, memr_n for a memory read, memw_n for a memory write.
- R6: A hold phase of exactly 2 clocks follows the strobe. All strobes are high and bus_active stays high.
- R7: done is high for exactly the one clock after the hold phase ends. In that clock bus_active is low and req_ready is high.
- R8: A read captures bus_din at the clock edge that ends the strobe. A 16-bit read returns all 16 bits; an 8-bit read returns {8'h00, bus_din[7:0]}. A write leaves rd_data unchanged.
- R9: During a write, bus_dout_en is high for the whole active cycle and bus_dout carries the write data. An 8-bit write drives the upper byte as zero. During a read, bus_dout_en is low.
- R10: With bit 10 set, a synchronised low on early_end_n ends the strobe. If the input is already low before the strobe starts, the strobe lasts 1 clock. If it falls in strobe clock j, the strobe lasts min(j + 2, strobe-extra + 2). With bit 10 clear, the input has no effect.
- R11: sbhe_n is low throughout every active 16-bit cycle and high during 8-bit cycles.
- R12: A request presented while a cycle is in progress is ignored. The running cycle keeps its address, and no second cycle starts after done.
- R13: alt_pinout follows configuration bit 11 and osc_sel follows bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| alt_pinout | output | 1 | Alternate pin arrangement select |
| osc_sel | output | 1 | Bus oscillator select |
| req_valid | input | 1 | Host request present |
| req_addr | input | 32 | Host address; top byte selects the cycle kind |
| req_wdata | input | 16 | Host write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | High when a request can be taken |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| bus_addr | output | 24 | Bus address |
| bus_dout | output | 16 | Bus write data |
| bus_dout_en | output | 1 | Bus data driver enable |
| bus_din | input | 16 | Bus read data |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| sbhe_n | output | 1 | High-byte enable, active low |
| bus_active | output | 1 | Address and data valid (setup, strobe, hold) |
| early_end_n | input | 1 | Target early-end request, active low, asynchronous |

## Verification
A request accepted at one clock edge starts setup in the next clock. The strobe falls after setup-extra + 2 clocks, rises after another strobe-extra + 2 clocks (or fewer with early end), bus_active drops 2 clocks later, and done appears in that same clock. The bench drives inputs and samples at falling edges only. It walks one sample per clock through each cycle, counting the clocks of each phase from the bus pins themselves, and compares the counts with lengths it computes from the fields it wrote. For early end it adds the two synchroniser clocks in its own formula: 1 clock when the input was low before the strobe, j + 2 clocks when it falls in strobe clock j. It checks rd_data in the clock done is seen.

// File: rtl/isa_pkg.sv
package isa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } isa_state_e;

  typedef struct packed {
    logic hit;
    logic is_io;
    logic wide;
  } isa_win_t;

  // Top address byte -> cycle kind
  function automatic isa_win_t decode_window(input logic [7:0] top);
    isa_win_t w;
    w = '0;
    case (top)
      8'hEC: w = '{hit: 1'b1, is_io: 1'b0, wide: 1'b0};
      8'hED: w = '{hit: 1'b1, is_io: 1'b0, wide: 1'b1};
      8'hEE: w = '{hit: 1'b1, is_io: 1'b1, wide: 1'b0};
      8'hEF: w = '{hit: 1'b1, is_io: 1'b1, wide: 1'b1};
      default: w = '0;
    endcase
    return w;
  endfunction

  // Phase of (extra + 2) clocks: down-counter starts at extra + 1, ends at 0
  function automatic logic [7:0] phase_last(input logic [7:0] extra);
    return extra + 8'd1;
  endfunction

endpackage

// File: rtl/isa_sync2.sv
module isa_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/isa_cfg_reg.sv
module isa_cfg_reg #(
  parameter int unsigned STB_W   = 6,
  parameter int unsigned SET_W   = 4,
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned STB_RST = 40,
  parameter int unsigned SET_RST = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [STB_W-1:0] strobe_extra,
  output logic [SET_W-1:0] setup_extra,
  output logic             honor_early,
  output logic             alt_pin,
  output logic             osc_sel
);
  localparam int unsigned SET_LO  = STB_W;
  localparam int unsigned HON_BIT = STB_W + SET_W;
  localparam int unsigned ALT_BIT = HON_BIT + 1;
  localparam int unsigned OSC_BIT = HON_BIT + 2;
  localparam int unsigned USED    = OSC_BIT + 1;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata[CFG_W-1:USED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_extra <= STB_W'(STB_RST);
      setup_extra  <= SET_W'(SET_RST);
      honor_early  <= 1'b0;
      alt_pin      <= 1'b0;
      osc_sel      <= 1'b0;
    end else if (we) begin
      strobe_extra <= wdata[STB_W-1:0];
      setup_extra  <= wdata[SET_LO +: SET_W];
      honor_early  <= wdata[HON_BIT];
      alt_pin      <= wdata[ALT_BIT];
      osc_sel      <= wdata[OSC_BIT];
    end
  end

  assign rdata = {{(CFG_W-USED){1'b0}}, osc_sel, alt_pin, honor_early,
                  setup_extra, strobe_extra};

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[USED-1:0] == $past(wdata[USED-1:0])));

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_pkg::*;
#(
  parameter int unsigned STB_W    = 6,
  parameter int unsigned SET_W    = 4,
  parameter int unsigned HA_W     = 32,
  parameter int unsigned BA_W     = 24,
  parameter int unsigned DW       = 16,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [HA_W-1:0]  req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_write,
  input  logic [STB_W-1:0] strobe_extra,
  input  logic [SET_W-1:0] setup_extra,
  input  logic             honor_early,
  input  logic             early_seen,
  input  logic [DW-1:0]    bus_din,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [BA_W-1:0]  bus_addr,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_dout_en,
  output logic             ior_n,
  output logic             iow_n,
  output logic             memr_n,
  output logic             memw_n,
  output logic             sbhe_n,
  output logic             bus_active
);
  localparam int unsigned CNT_W = ((STB_W > SET_W) ? STB_W : SET_W) + 1;
  localparam int unsigned HALF  = DW / 2;

  isa_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lat_io, lat_wide, lat_write, lat_honor;
  logic [STB_W-1:0] lat_stb;
  isa_win_t         win;

  // Named internal events
  logic accept, setup_end, strobe_end, hold_end, early_cut, strobe_on;

  assign win        = decode_window(req_addr[HA_W-1 -: 8]);
  assign accept     = req_valid && (state_q == ST_IDLE) && win.hit;
  assign strobe_on  = (state_q == ST_STROBE);
  assign early_cut  = strobe_on && lat_honor && early_seen;
  assign setup_end  = (state_q == ST_SETUP) && (cnt_q == '0);
  assign strobe_end = strobe_on && ((cnt_q == '0) || early_cut);
  assign hold_end   = (state_q == ST_HOLD) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lat_io    <= 1'b0;
      lat_wide  <= 1'b0;
      lat_write <= 1'b0;
      lat_honor <= 1'b0;
      lat_stb   <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      done <= hold_end;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q   <= ST_SETUP;
            cnt_q     <= CNT_W'(phase_last(8'(setup_extra)));
            lat_io    <= win.is_io;
            lat_wide  <= win.wide;
            lat_write <= req_write;
            lat_honor <= honor_early;
            lat_stb   <= strobe_extra;
            bus_addr  <= req_addr[BA_W-1:0];
            bus_dout  <= win.wide ? req_wdata
                                  : {{(DW-HALF){1'b0}}, req_wdata[HALF-1:0]};
          end
        end
        ST_SETUP: begin
          if (setup_end) begin
            state_q <= ST_STROBE;
            cnt_q   <= CNT_W'(phase_last(8'(lat_stb)));
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STROBE: begin
          if (strobe_end) begin
            state_q <= ST_HOLD;
            cnt_q   <= CNT_W'(HOLD_CYC - 1);
            if (!lat_write)
              rd_data <= lat_wide ? bus_din
                                  : {{(DW-HALF){1'b0}}, bus_din[HALF-1:0]};
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: begin
          if (hold_end) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign bus_active  = (state_q != ST_IDLE);
  assign bus_dout_en = bus_active && lat_write;
  assign sbhe_n      = !(bus_active && lat_wide);
  assign ior_n       = !(strobe_on &&  lat_io && !lat_write);
  assign iow_n       = !(strobe_on &&  lat_io &&  lat_write);
  assign memr_n      = !(strobe_on && !lat_io && !lat_write);
  assign memw_n      = !(strobe_on && !lat_io &&  lat_write);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ior_n, iow_n, memr_n, memw_n}) >= 3);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && $past(bus_active)) |-> ($stable(bus_addr) && $stable(bus_dout)));

  p_hold_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ior_n & iow_n & memr_n & memw_n) |-> bus_active);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_active && req_ready));

endmodule

// File: rtl/isa_cycle_gen.sv
module isa_cycle_gen #(
  parameter int unsigned STB_W    = 6,
  parameter int unsigned SET_W    = 4,
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned HA_W     = 32,
  parameter int unsigned BA_W     = 24,
  parameter int unsigned DW       = 16,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             alt_pinout,
  output logic             osc_sel,
  input  logic             req_valid,
  input  logic [HA_W-1:0]  req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_write,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [BA_W-1:0]  bus_addr,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_dout_en,
  input  logic [DW-1:0]    bus_din,
  output logic             ior_n,
  output logic             iow_n,
  output logic             memr_n,
  output logic             memw_n,
  output logic             sbhe_n,
  output logic             bus_active,
  input  logic             early_end_n
);
  logic [STB_W-1:0] strobe_extra;
  logic [SET_W-1:0] setup_extra;
  logic             honor_early;
  logic             early_sync_n;
  logic             early_seen;

  isa_cfg_reg #(
    .STB_W(STB_W), .SET_W(SET_W), .CFG_W(CFG_W), .STB_RST(40), .SET_RST(14)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .strobe_extra(strobe_extra), .setup_extra(setup_extra),
    .honor_early(honor_early), .alt_pin(alt_pinout), .osc_sel(osc_sel)
  );

  isa_sync2 #(.RST_VAL(1'b1)) u_early_sync (
    .clk(clk), .rst_n(rst_n), .d(early_end_n), .q(early_sync_n)
  );

  assign early_seen = !early_sync_n;

  isa_cycle_seq #(
    .STB_W(STB_W), .SET_W(SET_W), .HA_W(HA_W), .BA_W(BA_W), .DW(DW),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write),
    .strobe_extra(strobe_extra), .setup_extra(setup_extra),
    .honor_early(honor_early), .early_seen(early_seen),
    .bus_din(bus_din),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .sbhe_n(sbhe_n), .bus_active(bus_active)
  );

endmodule

// File: tb/isa_cycle_gen_tb_top.sv
module isa_cycle_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        alt_pinout, osc_sel;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout;
  logic        bus_dout_en;
  logic [15:0] bus_din = '0;
  logic        ior_n, iow_n, memr_n, memw_n, sbhe_n, bus_active;
  logic        early_end_n = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  int unsigned m_stb = 40, m_set = 14;
  bit m_hon = 1'b0;
  logic [15:0] last_rd = '0;

  always #2 clk = ~clk;

  isa_cycle_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .alt_pinout(alt_pinout), .osc_sel(osc_sel),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .ior_n(ior_n),
    .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n), .sbhe_n(sbhe_n),
    .bus_active(bus_active), .early_end_n(early_end_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_strobes(input bit io, input bit wr);
    if (io) return wr ? 4'b1011 : 4'b0111;
    return wr ? 4'b1110 : 4'b1101;
  endfunction

  function automatic int unsigned exp_strobe_len(input int unsigned stb,
                                                 input bit hon, input int mode);
    int unsigned full;
    full = stb + 2;
    if (!hon || mode < 0) return full;
    if (mode == 0) return 1;
    return (int'(full) < mode + 2) ? full : unsigned'(mode + 2);
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    m_stb = w[5:0]; m_set = w[9:6]; m_hon = w[10];
    chk(cfg_rdata == {19'd0, w[12:0]}, "R2 cfg readback", cfg_rdata, {19'd0, w[12:0]});
    chk(alt_pinout == w[11] && osc_sel == w[12], "R13 alt/osc outputs",
        {alt_pinout, osc_sel}, {w[11], w[12]});
  endtask

  // mode: -1 no early end, 0 low before strobe, j>0 falls in strobe clock j
  task automatic run_cycle(input logic [31:0] a, input logic [15:0] wd, input bit wr,
                           input logic [15:0] din, input int mode, input bit poke);
    bit hit, io, wide;
    int unsigned n_set, n_stb, n_hold, e_stb;
    bit bad_addr, bad_dout, bad_sbhe, bad_pat, bad_done, ended;
    logic [3:0] pat;
    hit  = (a[31:24] >= 8'hEC) && (a[31:24] <= 8'hEF);
    io   = a[25];
    wide = a[24];
    n_set = 0; n_stb = 0; n_hold = 0;
    bad_addr = 0; bad_dout = 0; bad_sbhe = 0; bad_pat = 0; bad_done = 0; ended = 0;
    e_stb = exp_strobe_len(m_stb, m_hon, mode);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr; bus_din = din;
    if (mode == 0) early_end_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      for (int i = 0; i < 4; i++) begin
        if (bus_active || done || !req_ready) bad_done = 1;
        @(negedge clk);
      end
      chk(!bad_done, "R3 unmapped request ignored", {bus_active, done, req_ready}, 32'b001);
      return;
    end
    for (int i = 0; i < 300; i++) begin
      if (!bus_active) begin ended = 1; break; end
      if (done) bad_done = 1;
      if (bus_addr != a[23:0]) bad_addr = 1;
      if (bus_dout_en != wr) bad_dout = 1;
      if (wr && bus_dout != (wide ? wd : {8'h00, wd[7:0]})) bad_dout = 1;
      if (sbhe_n != !wide) bad_sbhe = 1;
      pat = {ior_n, iow_n, memr_n, memw_n};
      if (pat != 4'b1111) begin
        n_stb++;
        if (pat != exp_strobes(io, wr) || n_hold != 0) bad_pat = 1;
        if (mode > 0 && n_stb == unsigned'(mode)) early_end_n = 1'b0;
      end else if (n_stb == 0) begin
        n_set++;
        if (poke && n_set == 1) begin
          req_valid = 1'b1; req_addr = 32'hEF0000AA; req_write = !wr;
        end
      end else begin
        n_hold++;
      end
      @(negedge clk);
      if (poke && n_set == 1) req_valid = 1'b0;
    end
    early_end_n = 1'b1;
    chk(ended, "R7 cycle finished", 32'(ended), 1);
    chk(n_set == m_set + 2, "R4 setup length", n_set, m_set + 2);
    chk(!bad_addr, "R4 address stable", 32'(bus_addr), a[23:0]);
    chk(n_stb == e_stb, (mode >= 0) ? "R10 early-end strobe length" : "R5 strobe length",
        n_stb, e_stb);
    chk(!bad_pat, "R5 strobe select", 32'(bad_pat), 0);
    chk(n_hold == 2, "R6 hold length", n_hold, 2);
    chk(!bad_dout, "R9 write data drive", 32'(bad_dout), 0);
    chk(!bad_sbhe, "R11 high-byte enable", 32'(bad_sbhe), 0);
    chk(done && req_ready && !bad_done, "R7 done pulse", {done, req_ready, bad_done}, 32'b110);
    if (!wr) last_rd = wide ? din : {8'h00, din[7:0]};
    chk(rd_data == last_rd, "R8 read data", rd_data, last_rd);
    @(negedge clk);
    chk(!done && !bus_active, "R7 R12 single done, no further cycle",
        {done, bus_active}, 0);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'h3A8, "R1 reset config", cfg_rdata, 32'h3A8);
    chk({ior_n, iow_n, memr_n, memw_n} == 4'hF && !bus_active && !done && req_ready,
        "R1 reset outputs", {ior_n, iow_n, memr_n, memw_n, bus_active, done, req_ready},
        32'b1111001);
    rst_n = 1'b1;
    @(negedge clk);
    // Default timing, each cycle kind
    run_cycle(32'hED001234, 16'h0, 1'b0, 16'hA55A, -1, 1'b0);  // 16-bit mem read
    run_cycle(32'hEE000100, 16'hBEEF, 1'b1, 16'h0, -1, 1'b0);  // 8-bit io write
    run_cycle(32'hE8000004, 16'h0, 1'b0, 16'h1111, -1, 1'b0);  // unmapped
    run_cycle(32'hEC00FFFF, 16'h0, 1'b0, 16'hC3F0, -1, 1'b1);  // 8-bit mem read, busy poke
    // Upper config bits ignored
    write_cfg(32'hFFFFFFFF);
    // Minimum lengths, early end honoured from the start
    write_cfg(32'h00000400);
    run_cycle(32'hEF000300, 16'h1234, 1'b1, 16'h0, 0, 1'b0);
    // Early end mid strobe
    write_cfg(32'h00000400 | 32'd10 | (32'd3 << 6));
    run_cycle(32'hEF000302, 16'h0, 1'b0, 16'h7E81, 3, 1'b0);
    // Early end ignored when not enabled
    write_cfg(32'd10 | (32'd3 << 6));
    run_cycle(32'hEC000010, 16'h00AB, 1'b1, 16'h0, 0, 1'b0);
    // Random mix
    for (int k = 0; k < 40; k++) begin
      if (k % 4 == 0) write_cfg($urandom & 32'h1FFF);
      a = {8'hEC + 8'($urandom % 5), 24'($urandom)};
      run_cycle(a, 16'($urandom), 1'($urandom), 16'($urandom),
                int'($urandom % 8) - 1, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule